// File: doc/BRIEF.md
# Concurrent Round-Robin Clos Cell Dispatcher

This block picks, once per time slot, which virtual output queues of a three-stage Clos switch may send a cell. The switch has `NUM_MOD` input modules and `NUM_MOD` output modules of `PORTS` ports each, joined by `NUM_CM` central modules. Each input module has one link to every central module. Each central module has one link to every output module. Every input module keeps `NUM_MOD*PORTS` queues, one per destination output-module port.

A slot is started by a one-cycle `slot_go`. In that cycle the block runs one matching pass inside every input module. Each link offers itself to a requesting queue, and each queue accepts at most one offering link. Each central module then settles contention for each of its output-module links. The winners are registered. One cycle later they appear as one-hot vectors, together with a `slot_done` pulse.

The round-robin pointers move only for requests that the central module grants. Under saturated load the pointers drift apart and contention dies out.

Top module: `crrd_dispatch`

## Requirements
- R1: While reset is asserted and after it is released, `vq_win`, `link_sel` and `slot_done` are zero. Every queue, link and central-module pointer starts at 0.
- R2: Every queue whose bit in `vq_req` is set requests in every slot. A queue whose bit is clear never wins.
- R3: Link r of input module i offers itself to the first requesting queue at or after that link's pointer, in cyclic order.
- R4: A queue accepts the first offering link at or after its own pointer, in cyclic order. In `link_sel`, each link carries at most one queue and each queue uses at most one link.
- R5: For each output module j, central module r grants the first input module, at or after its pointer for j, whose matched link carries a cell for j. At most one such grant is made per (r, j).
- R6: On a central-module grant, the three pointers involved move to one past their winner: the queue pointer to link r+1, the link pointer to queue v+1, and the central pointer to input module i+1. Each wraps at its modulus.
- R7: A request that is not granted leaves all pointers unchanged, and the queue competes again in the next slot.
- R8: Queue index v within an input module is h*NUM_MOD + j, where j is the output module and h is the port. `vq_win` bit i*Q+v marks queue v of input module i, with Q = NUM_MOD*PORTS. `link_sel` bits (i*NUM_CM+r)*Q +: Q give the one-hot queue that won on link r of input module i.
- R9: Results are registered on the `slot_go` edge and held until the next `slot_go`. `slot_done` is high for exactly the one cycle that follows `slot_go`.
- R10: With NUM_MOD=PORTS=NUM_CM=2, all queues full and starting from reset, the slots deliver 1 cell, then 3 cells, then 4 cells in every later slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_go | input | 1 | Starts one dispatch slot |
| vq_req | input | NUM_MOD*NUM_MOD*PORTS | Occupancy, one bit per queue |
| vq_win | output | NUM_MOD*NUM_MOD*PORTS | Queues granted a path in the last slot |
| link_sel | output | NUM_MOD*NUM_CM*NUM_MOD*PORTS | Winning queue per input-module link, one-hot |
| slot_done | output | 1 | One-cycle pulse when results are valid |

## Verification
The bench builds the block with two input modules, two ports each and two central modules. These are the smallest values at which every arbiter sees real contention and each pointer can wrap. They bring the saturated desynchronisation sequence, including exact link choices, within reach as fixed expected vectors. Directed runs from reset then cover an empty slot, a lone queue with the highest index, and two queues colliding at one central module, whose loser must succeed on the next slot with its pointers untouched.

// File: rtl/crrd_pkg.sv
package crrd_pkg;

  // bits needed to hold an index in [0, span)
  function automatic int ptr_bits(input int span);
    return (span > 1) ? $clog2(span) : 1;
  endfunction

  // cyclic sum
  function automatic int ring_add(input int a, input int b, input int span);
    return (a + b) % span;
  endfunction

  // one past the winner, wrapping
  function automatic int ring_next(input int at, input int span);
    return (at + 1) % span;
  endfunction

  // output module addressed by queue index v = h*K + j
  function automatic int queue_dest(input int v, input int k);
    return v % k;
  endfunction

endpackage

// File: rtl/crrd_rr_pick.sv
module crrd_rr_pick
  import crrd_pkg::*;
#(
  parameter int W  = 4,
  parameter int PW = ptr_bits(W)
) (
  input  logic [W-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [W-1:0]  gnt
);
  // first requester at or after ptr, cyclic
  always_comb begin
    logic hit;
    hit = 1'b0;
    gnt = '0;
    for (int off = 0; off < W; off++) begin
      int c;
      c = ring_add(int'(ptr), off, W);
      if (!hit && req[c]) begin
        hit    = 1'b1;
        gnt[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/crrd_im_match.sv
module crrd_im_match
  import crrd_pkg::*;
#(
  parameter int Q   = 4,
  parameter int M   = 2,
  parameter int K   = 2,
  parameter int PWQ = ptr_bits(Q),
  parameter int PWM = ptr_bits(M),
  parameter int PWK = ptr_bits(K)
) (
  input  logic [Q-1:0]     req,
  input  logic [M*PWQ-1:0] pl_ptr,
  input  logic [Q*PWM-1:0] pv_ptr,
  output logic [M*Q-1:0]   lnk_sel,
  output logic [M-1:0]     lnk_ok,
  output logic [M*PWQ-1:0] lnk_v,
  output logic [M*PWK-1:0] lnk_dest
);
  logic [Q-1:0] offer [M];  // link r offers to queue
  logic [M-1:0] seen  [Q];  // queue v sees offers from links
  logic [M-1:0] acc   [Q];  // queue v accepts link

  // link arbiters (R3)
  for (genvar r = 0; r < M; r++) begin : g_link
    crrd_rr_pick #(.W(Q), .PW(PWQ)) u_pick (
      .req(req),
      .ptr(pl_ptr[r*PWQ +: PWQ]),
      .gnt(offer[r])
    );
  end

  always_comb begin
    for (int v = 0; v < Q; v++)
      for (int r = 0; r < M; r++)
        seen[v][r] = offer[r][v];
  end

  // queue accept arbiters (R4)
  for (genvar v = 0; v < Q; v++) begin : g_queue
    crrd_rr_pick #(.W(M), .PW(PWM)) u_pick (
      .req(seen[v]),
      .ptr(pv_ptr[v*PWM +: PWM]),
      .gnt(acc[v])
    );
  end

  always_comb begin
    lnk_sel  = '0;
    lnk_v    = '0;
    lnk_dest = '0;
    for (int r = 0; r < M; r++) begin
      for (int v = 0; v < Q; v++) begin
        lnk_sel[r*Q + v] = acc[v][r];
        if (acc[v][r]) begin
          lnk_v[r*PWQ +: PWQ]    = PWQ'(v);
          lnk_dest[r*PWK +: PWK] = PWK'(queue_dest(v, K));
        end
      end
      lnk_ok[r] = |lnk_sel[r*Q +: Q];
    end
  end
endmodule

// File: rtl/crrd_cm_arb.sv
module crrd_cm_arb
  import crrd_pkg::*;
#(
  parameter int K   = 2,
  parameter int PWK = ptr_bits(K)
) (
  input  logic [K-1:0]     lnk_ok,
  input  logic [K*PWK-1:0] lnk_dest,
  input  logic [K*PWK-1:0] pc_ptr,
  output logic [K-1:0]     lnk_won,
  output logic [K*K-1:0]   out_gnt
);
  logic [K-1:0] want [K];  // per output module j, requesting input modules

  always_comb begin
    for (int j = 0; j < K; j++)
      for (int i = 0; i < K; i++)
        want[j][i] = lnk_ok[i] && (lnk_dest[i*PWK +: PWK] == PWK'(j));
  end

  // one arbiter per output-module link (R5)
  for (genvar j = 0; j < K; j++) begin : g_out
    crrd_rr_pick #(.W(K), .PW(PWK)) u_pick (
      .req(want[j]),
      .ptr(pc_ptr[j*PWK +: PWK]),
      .gnt(out_gnt[j*K +: K])
    );
  end

  always_comb begin
    lnk_won = '0;
    for (int j = 0; j < K; j++)
      lnk_won = lnk_won | out_gnt[j*K +: K];
  end
endmodule

// File: rtl/crrd_dispatch.sv
module crrd_dispatch
  import crrd_pkg::*;
#(
  parameter int NUM_MOD = 2,
  parameter int PORTS   = 2,
  parameter int NUM_CM  = 2
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      slot_go,
  input  logic [NUM_MOD*NUM_MOD*PORTS-1:0]          vq_req,
  output logic [NUM_MOD*NUM_MOD*PORTS-1:0]          vq_win,
  output logic [NUM_MOD*NUM_CM*NUM_MOD*PORTS-1:0]   link_sel,
  output logic                                      slot_done
);
  localparam int K   = NUM_MOD;
  localparam int M   = NUM_CM;
  localparam int Q   = NUM_MOD * PORTS;
  localparam int PWQ = ptr_bits(Q);
  localparam int PWM = ptr_bits(M);
  localparam int PWK = ptr_bits(K);

  // pointer state (R1, R6)
  logic [K*Q*PWM-1:0] pv_q;  // queue -> link pointer
  logic [K*M*PWQ-1:0] pl_q;  // link  -> queue pointer
  logic [M*K*PWK-1:0] pc_q;  // central module -> input module pointer

  // named internal events
  logic [M*Q-1:0]   im_sel  [K];
  logic [M-1:0]     im_ok   [K];
  logic [M*PWQ-1:0] im_v    [K];
  logic [M*PWK-1:0] im_dest [K];
  logic [K-1:0]     cm_ok   [M];
  logic [K*PWK-1:0] cm_dest [M];
  logic [K-1:0]     cm_won  [M];
  logic [K*K-1:0]   cm_gnt  [M];
  logic [K-1:0]     cm_fire [M];
  logic [K*PWK-1:0] cm_wi   [M];
  logic [K*M-1:0]   link_won;
  logic [K*M*Q-1:0] nxt_sel;
  logic [K*Q-1:0]   nxt_win;

  // input-module matching
  for (genvar i = 0; i < K; i++) begin : g_im
    crrd_im_match #(.Q(Q), .M(M), .K(K), .PWQ(PWQ), .PWM(PWM), .PWK(PWK)) u_im (
      .req     (vq_req[i*Q +: Q]),
      .pl_ptr  (pl_q[i*M*PWQ +: M*PWQ]),
      .pv_ptr  (pv_q[i*Q*PWM +: Q*PWM]),
      .lnk_sel (im_sel[i]),
      .lnk_ok  (im_ok[i]),
      .lnk_v   (im_v[i]),
      .lnk_dest(im_dest[i])
    );
  end

  // route link (i, r) to central module r
  always_comb begin
    for (int r = 0; r < M; r++) begin
      for (int i = 0; i < K; i++) begin
        cm_ok[r][i]               = im_ok[i][r];
        cm_dest[r][i*PWK +: PWK]  = im_dest[i][r*PWK +: PWK];
      end
    end
  end

  // central-module arbitration
  for (genvar r = 0; r < M; r++) begin : g_cm
    crrd_cm_arb #(.K(K), .PWK(PWK)) u_cm (
      .lnk_ok  (cm_ok[r]),
      .lnk_dest(cm_dest[r]),
      .pc_ptr  (pc_q[r*K*PWK +: K*PWK]),
      .lnk_won (cm_won[r]),
      .out_gnt (cm_gnt[r])
    );
  end

  // winner encoding per central output link
  always_comb begin
    for (int r = 0; r < M; r++) begin
      cm_wi[r] = '0;
      for (int j = 0; j < K; j++) begin
        cm_fire[r][j] = |cm_gnt[r][j*K +: K];
        for (int i = 0; i < K; i++)
          if (cm_gnt[r][j*K + i]) cm_wi[r][j*PWK +: PWK] = PWK'(i);
      end
    end
  end

  // slot results
  always_comb begin
    nxt_win = '0;
    for (int i = 0; i < K; i++) begin
      for (int r = 0; r < M; r++) begin
        link_won[i*M + r] = cm_won[r][i];
        nxt_sel[(i*M + r)*Q +: Q] = cm_won[r][i] ? im_sel[i][r*Q +: Q] : '0;
        nxt_win[i*Q +: Q] = nxt_win[i*Q +: Q] | nxt_sel[(i*M + r)*Q +: Q];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q      <= '0;
      pl_q      <= '0;
      pc_q      <= '0;
      vq_win    <= '0;
      link_sel  <= '0;
      slot_done <= 1'b0;
    end else if (slot_go) begin
      vq_win    <= nxt_win;
      link_sel  <= nxt_sel;
      slot_done <= 1'b1;
      for (int i = 0; i < K; i++) begin
        for (int r = 0; r < M; r++) begin
          if (link_won[i*M + r]) begin
            pl_q[(i*M + r)*PWQ +: PWQ] <=
              PWQ'(ring_next(int'(im_v[i][r*PWQ +: PWQ]), Q));
            pv_q[(i*Q + int'(im_v[i][r*PWQ +: PWQ]))*PWM +: PWM] <=
              PWM'(ring_next(r, M));
          end
        end
      end
      for (int r = 0; r < M; r++)
        for (int j = 0; j < K; j++)
          if (cm_fire[r][j])
            pc_q[(r*K + j)*PWK +: PWK] <=
              PWK'(ring_next(int'(cm_wi[r][j*PWK +: PWK]), K));
    end else begin
      slot_done <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  a_r9_done_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
    slot_go |=> slot_done);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_go |=> !slot_done);
  a_r2_empty_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    slot_go |=> ((vq_win & ~$past(vq_req)) == '0));
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_go |=> ($stable(vq_win) && $stable(link_sel) && $stable(pc_q) && $stable(pl_q)));

  for (genvar l = 0; l < K*M; l++) begin : g_chk_link
    a_r4_link_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(link_sel[l*Q +: Q]));
    a_r7_unused_link_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_go && !link_won[l]) |=> $stable(pl_q[l*PWQ +: PWQ]));
  end

  for (genvar r = 0; r < M; r++) begin : g_chk_cm
    for (genvar j = 0; j < K; j++) begin : g_out
      a_r5_cm_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cm_gnt[r][j*K +: K]));
    end
  end
endmodule

// File: tb/crrd_dispatch_test.sv
module crrd_dispatch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_go = 1'b0;
  logic [7:0]  vq_req = '0;
  logic [7:0]  vq_win;
  logic [15:0] link_sel;
  logic        slot_done;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crrd_dispatch #(.NUM_MOD(2), .PORTS(2), .NUM_CM(2)) uut (
    .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .vq_req(vq_req),
    .vq_win(vq_win), .link_sel(link_sel), .slot_done(slot_done)
  );

  // {request, expected win, expected link_sel}: saturated run from reset (R10, R8)
  localparam logic [31:0] SAT_TAB [3] = '{
    {8'hFF, 8'h01, 16'h0001},
    {8'hFF, 8'h13, 16'h0112},
    {8'hFF, 8'h36, 16'h1224}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; slot_go = 1'b0; vq_req = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_slot(input logic [7:0] r);
    @(negedge clk);
    vq_req = r; slot_go = 1'b1;
    @(negedge clk);
    slot_go = 1'b0;
  endtask

  function automatic int pop8(input logic [7:0] x);
    int c = 0;
    for (int b = 0; b < 8; b++) c += x[b];
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 win in reset", 32'(vq_win), 0);
    chk("R1 link_sel in reset", 32'(link_sel), 0);
    chk("R1 done in reset", 32'(slot_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 win after reset", 32'(vq_win), 0);

    // R10 saturated desynchronisation sequence
    for (int s = 0; s < 3; s++) begin
      do_slot(SAT_TAB[s][31:24]);
      chk("R9 done after go", 32'(slot_done), 1);
      chk($sformatf("R10 R8 win slot %0d", s), 32'(vq_win), 32'(SAT_TAB[s][23:16]));
      chk($sformatf("R3 R4 link_sel slot %0d", s), 32'(link_sel), 32'(SAT_TAB[s][15:0]));
    end
    for (int s = 3; s < 8; s++) begin
      do_slot(8'hFF);
      chk($sformatf("R10 four cells slot %0d", s), 32'(pop8(vq_win)), 4);
    end

    // R9 hold while idle, done pulse single
    begin
      logic [7:0] held;
      held = vq_win;
      repeat (3) @(negedge clk);
      chk("R9 done drops", 32'(slot_done), 0);
      chk("R9 win held", 32'(vq_win), 32'(held));
    end

    // R2 empty slot, then R6/R7 no pointer moved
    do_reset();
    do_slot(8'h00);
    chk("R2 empty slot win", 32'(vq_win), 0);
    chk("R2 empty slot links", 32'(link_sel), 0);
    do_slot(8'hFF);
    chk("R7 pointers unchanged after empty", 32'(vq_win), 32'h01);

    // R3/R4/R8 lone queue: module 1, queue 3 (port 1, output module 1)
    do_reset();
    do_slot(8'h80);
    chk("R8 lone queue win", 32'(vq_win), 32'h80);
    chk("R4 lone queue on link 0", 32'(link_sel), 32'h0800);

    // R5/R7 contention at one central module, loser retries
    do_reset();
    do_slot(8'h11);
    chk("R5 lowest module wins", 32'(vq_win), 32'h01);
    chk("R5 winner link", 32'(link_sel), 32'h0001);
    do_slot(8'h11);
    chk("R7 loser retries and wins", 32'(vq_win), 32'h11);
    chk("R6 winner moved to link 1, loser kept link 0", 32'(link_sel), 32'h0110);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule